// File: doc/BRIEF.md
# Incrementing-Burst Read Responder

This block is a memory-backed subordinate on a read address channel and a read data channel. A requester presents one address handshake that carries a start address, a size code, a beat-count field and a burst type. The responder then returns a stream of data beats from an internal register array and marks the final one. Only the start address crosses the address channel. The responder works out each later beat address itself by stepping from the start address by the transfer size.

Only one burst is in flight at a time. The responder refuses a new address while it is still returning beats, and the requester may hold off any data beat by keeping ready low. A burst type other than incrementing, or a size code wider than the data bus, still produces the full number of beats, but each of them carries an error response.

The register array is filled at reset with a fixed pattern derived from each word's index. Every returned beat therefore identifies the word it came from.

Top module: `incr_read_resp`

## Requirements
- R1: While reset is held and right after it, `rd_valid` is low and `addr_ready` is high.
- R2: For an incrementing burst (type code 2'b01) with a legal size, beat n is read at address (start + n·2^size) mod 2^ADDR_W. The returned data is the whole 32-bit word that contains that address, and that word sits at index (address >> 2) mod MEM_WORDS. Size codes 0, 1 and 2 step the address by 1, 2 and 4 bytes.
- R3: `addr_ready` is low from the cycle after an address handshake until the last beat's handshake, so at most one burst is outstanding. `rd_valid` is high in the cycle after the address handshake.
- R4: While `rd_valid` is high and `rd_ready` is low, `rd_data`, `rd_last` and `rd_resp` hold their values into the next cycle, and the burst does not advance.
- R5: A burst delivers exactly length-field-plus-one beats, up to 256 beats for length 255. `rd_last` is high only on the final beat, and `rd_valid` drops in the cycle after the final beat's handshake.
- R6: Every beat of an incrementing burst with a legal size carries response 2'b00 (OKAY).
- R7: A burst type other than 2'b01 returns length-plus-one beats, each with response 2'b10 (SLVERR) and data zero.
- R8: A size code above 2 returns length-plus-one beats, each with response 2'b10 and data zero, whatever the burst type.
- R9: At reset, word i of the array holds {~i[15:0], i[15:0]}, with the upper half in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | Address request valid |
| addr_ready | output | 1 | Responder can take an address |
| addr_start | input | ADDR_W | Byte address of the first beat |
| addr_size | input | 3 | log2 of bytes per beat |
| addr_len | input | 8 | Beats in the burst minus one |
| addr_burst | input | 2 | Burst type code, 2'b01 incrementing |
| rd_valid | output | 1 | Data beat valid |
| rd_ready | input | 1 | Requester accepts the beat |
| rd_data | output | 32 | Beat data |
| rd_resp | output | 2 | 2'b00 OKAY, 2'b10 SLVERR |
| rd_last | output | 1 | Final beat of the burst |

## Verification
A wrong step or a stale base address shows up on the first beat that follows a bad increment. Each word carries its own index, so the data reveals which word was read. A beat counter that slips or compares against the wrong length shows as `rd_last` appearing too early or too late, or as `rd_valid` staying high past the expected beat count. The problem is visible within the same burst. An advance during a stall shows as data changing while ready is low, and a mis-latched error flag shows as a wrong response code on the very first beat.

// File: rtl/incr_read_resp.sv
module incr_read_resp #(
  parameter int ADDR_W    = 16,
  parameter int MEM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  output logic              addr_ready,
  input  logic [ADDR_W-1:0] addr_start,
  input  logic [2:0]        addr_size,
  input  logic [7:0]        addr_len,
  input  logic [1:0]        addr_burst,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [31:0]       rd_data,
  output logic [1:0]        rd_resp,
  output logic              rd_last
);
  localparam int DATA_W   = 32;
  localparam int IDX_W    = $clog2(MEM_WORDS);
  localparam int MAX_SIZE = $clog2(DATA_W / 8);

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic              busy;
  logic              err;
  logic [ADDR_W-1:0] cur;
  logic [2:0]        size;
  logic [7:0]        len;
  logic [7:0]        cnt;

  wire take    = addr_valid && addr_ready;
  wire advance = rd_valid && rd_ready;
  wire [IDX_W-1:0] idx = cur[IDX_W+1:2];

  assign addr_ready = !busy;
  assign rd_valid   = busy;
  assign rd_last    = busy && (cnt == len);
  assign rd_resp    = err ? 2'b10 : 2'b00;
  assign rd_data    = err ? '0 : mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      err  <= 1'b0;
      cur  <= '0;
      size <= '0;
      len  <= '0;
      cnt  <= '0;
      for (int i = 0; i < MEM_WORDS; i++)
        mem[i] <= {~16'(i), 16'(i)};
    end else if (take) begin
      busy <= 1'b1;
      err  <= (addr_burst != 2'b01) || (int'(addr_size) > MAX_SIZE);
      cur  <= addr_start;
      size <= addr_size;
      len  <= addr_len;
      cnt  <= '0;
    end else if (advance) begin
      if (rd_last) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 8'd1;
        cur <= cur + (ADDR_W'(1) << size);
      end
    end
  end

  AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready |=> rd_valid && !addr_ready) else $error("accept"); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_last) && $stable(rd_resp)) else $error("stall"); // R4
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && rd_last |=> !rd_valid && addr_ready) else $error("close"); // R5
  AST_RESP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !rd_last |=> $stable(rd_resp)) else $error("resp"); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_resp == 2'b10 |-> rd_data == '0) else $error("errdata"); // R8
endmodule

// File: tb/sim_incr_read_resp.sv
module sim_incr_read_resp;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int MEM_WORDS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_valid = 1'b0, addr_ready;
  logic [ADDR_W-1:0] addr_start = '0;
  logic [2:0] addr_size = '0;
  logic [7:0] addr_len = '0;
  logic [1:0] addr_burst = '0;
  logic rd_valid, rd_ready = 1'b0, rd_last;
  logic [31:0] rd_data;
  logic [1:0] rd_resp;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  incr_read_resp #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u0 (
    .clk, .rst_n, .addr_valid, .addr_ready, .addr_start, .addr_size, .addr_len,
    .addr_burst, .rd_valid, .rd_ready, .rd_data, .rd_resp, .rd_last);

  function automatic logic [31:0] word_at(logic [ADDR_W-1:0] a);
    int i = int'(a >> 2) % MEM_WORDS;
    return {~16'(i), 16'(i)};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic burst(logic [ADDR_W-1:0] base, logic [2:0] sz, logic [7:0] ln,
                       logic [1:0] bt, int stall_pct);
    bit bad = (bt != 2'b01) || (sz > 3'd2);
    int n = 0;
    bit was_stall = 1'b0;
    logic [31:0] pd; logic pl; logic [1:0] pr;
    @(negedge clk);
    chk(addr_ready == 1'b1, "R3", "idle ready", addr_ready, 1);
    addr_valid = 1'b1; addr_start = base; addr_size = sz; addr_len = ln; addr_burst = bt;
    while (n <= int'(ln)) begin
      @(negedge clk);
      addr_valid = 1'b0;
      rd_ready = ($urandom % 100) >= stall_pct;
      if (was_stall) begin
        chk(rd_data == pd && rd_last == pl && rd_resp == pr, "R4", "stall hold", rd_data, pd);
      end
      chk(rd_valid == 1'b1 && addr_ready == 1'b0, "R3", "busy", {rd_valid, addr_ready}, 2'b10);
      if (bad) begin
        chk(rd_resp == 2'b10, (bt != 2'b01) ? "R7" : "R8", "err resp", rd_resp, 2'b10);
        chk(rd_data == 32'h0, (bt != 2'b01) ? "R7" : "R8", "err data", rd_data, 0);
      end else begin
        logic [ADDR_W-1:0] a = base + (ADDR_W'(n) << sz);
        chk(rd_resp == 2'b00, "R6", "okay resp", rd_resp, 0);
        chk(rd_data == word_at(a), "R2", "beat data", rd_data, word_at(a));
      end
      chk(rd_last == (n == int'(ln)), "R5", "last flag", rd_last, n == int'(ln));
      pd = rd_data; pl = rd_last; pr = rd_resp;
      was_stall = !rd_ready;
      if (rd_ready) n++;
    end
    @(negedge clk);
    rd_ready = 1'b0;
    chk(rd_valid == 1'b0 && addr_ready == 1'b1, "R5", "burst closed", {rd_valid, addr_ready}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0 && addr_ready == 1'b1, "R1", "in reset", {rd_valid, addr_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_valid == 1'b0 && addr_ready == 1'b1, "R1", "after reset", {rd_valid, addr_ready}, 2'b01);
    chk(word_at(16'h000C) == 32'hFFFC_0003, "R9", "pattern", word_at(16'h000C), 32'hFFFC0003);
    burst(16'h1000, 3'd2, 8'd3, 2'b01, 0);   // R2 four words
    burst(16'h1003, 3'd0, 8'd6, 2'b01, 30);  // R2 byte steps
    burst(16'h2002, 3'd1, 8'd5, 2'b01, 30);  // R2 halfword steps
    burst(16'h0000, 3'd2, 8'd0, 2'b01, 0);   // R5 single beat
    burst(16'hFFF8, 3'd2, 8'd255, 2'b01, 10); // R5 256 beats, wraps
    burst(16'h0100, 3'd2, 8'd3, 2'b00, 40);  // R7 fixed
    burst(16'h0100, 3'd2, 8'd2, 2'b10, 40);  // R7 wrap
    burst(16'h0100, 3'd3, 8'd2, 2'b01, 40);  // R8 oversize
    for (int k = 0; k < 40; k++) begin
      logic [1:0] bt = (($urandom % 4) == 0) ? 2'($urandom) : 2'b01;
      logic [2:0] sz = (($urandom % 6) == 0) ? 3'($urandom) : 3'($urandom % 3);
      burst(16'($urandom), sz, 8'($urandom % 20), bt, 35);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule